// File: doc/BRIEF.md
# Address-Range Cache Maintenance Sequencer

This block lets software clean, invalidate, or clean-and-invalidate every cache line that overlaps a physical address range with one command. Software programs a base address and an exclusive limit address into 64-bit registers. It then writes a command word that names the operation. The sequencer walks the range one 64-byte line at a time. For each line it sends one request to the cache over a valid/ready port.

Each command write starts a complete walk over the whole range. Bit 0 of the command register reads as 1 while the walk runs and clears by itself once the cache has taken the final line request. Software polls that bit to learn that the range is done. The base is rounded down to a line boundary and the limit is rounded up. A range that is empty after rounding, or a command with the reserved operation code, finishes at once and sends nothing.

Top module: `range_maint_engine`

## Requirements
- R1: Registers sit at byte offsets 0x00 (base), 0x08 (limit) and 0x10 (command). The base and limit keep only bits 39:0 of the written value, and bits 63:40 read back as zero. Any other offset reads as zero.
- R2: A write to offset 0x10 starts a walk, and command bit 0 reads 1 in the cycle after that write. Bit 0 reads 0 in the cycle after the final line request is accepted.
- R3: Line requests carry a line index equal to address bits 39:6. The first index is base[39:6], and each accepted request raises the index by one.
- R4: The limit is exclusive and rounded up to a whole line. The last index sent is the line that holds limit minus one, including a line that the limit only partly covers.
- R5: If the rounded limit is not above the rounded-down base, the command sends no request and bit 0 reads 0 in the cycle after the write.
- R6: Command bits 2:1 select the operation: 0 is clean-and-invalidate, 1 is invalidate without write-back, and 2 is clean-shared. The code appears unchanged on the request op field and reads back in command bits 2:1.
- R7: Operation code 3 is reserved. A command with code 3 sends no request and leaves bit 0 at 0.
- R8: While valid is high and ready is low, the request stays valid and its index and op hold their values.
- R9: While bit 0 is 1, writes to all three registers are ignored. The walk in progress continues unchanged.
- R10: A synchronous active-high reset clears all registers, drops valid and clears bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register write byte offset |
| wrData | input | 64 | Register write data |
| rdAddr | input | 5 | Register read byte offset |
| rdData | output | 64 | Register read data (combinational) |
| reqValid | output | 1 | Line request valid |
| reqReady | input | 1 | Cache accepts the line request |
| reqOp | output | 2 | Maintenance operation code |
| reqLine | output | 34 | Line index (address bits 39:6) |

## Verification
The bench uses the default parameters: a 40-bit address and a 64-byte line, which give a 34-bit line index. With these values a range at the very top of the address space can be tested. There, rounding the limit up carries past bit 39, and the bench expects the walk to cover exactly that last line. Ranges that start or end partway through a line, ranges that fall inside one line, empty and inverted ranges, and stalls from a toggling ready are all checked against line lists computed in the bench.

// File: rtl/rme_pkg.sv
package rme_pkg;

  typedef enum logic [1:0] {
    OP_CLEAN_INV    = 2'd0,
    OP_INV          = 2'd1,
    OP_CLEAN_SHARED = 2'd2,
    OP_RSVD         = 2'd3
  } maintOp_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadBase;
    logic loadLimit;
    logic launch;
    logic step;
  } ctlStrobe_t;

endpackage

// File: rtl/rme_datapath.sv
module rme_datapath
  import rme_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int LINE_SHIFT = 6,
  parameter int REG_W      = 64,
  parameter int OFF_W      = 5
) (
  input  logic                           clk,
  input  logic                           rst,
  input  ctlStrobe_t                     strobe,
  input  logic [REG_W-1:0]               wrData,
  input  logic                           busy,
  input  logic [OFF_W-1:0]               rdAddr,
  output logic [REG_W-1:0]               rdData,
  output logic                           rangeEmpty,
  output logic                           onLastLine,
  output logic [ADDR_W-LINE_SHIFT-1:0]   curLine,
  output maintOp_t                       curOp
);

  localparam int IDX_W = ADDR_W - LINE_SHIFT;
  localparam int PAD_W = REG_W - ADDR_W;
  localparam logic [OFF_W-1:0] OFF_BASE  = OFF_W'(8'h00);
  localparam logic [OFF_W-1:0] OFF_LIMIT = OFF_W'(8'h08);
  localparam logic [OFF_W-1:0] OFF_CMD   = OFF_W'(8'h10);

  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] limitAddr;
  logic [IDX_W-1:0]  baseLine;
  logic [IDX_W:0]    limitLineX;   // rounded-up exclusive line, one extra bit
  logic              unusedHi;

  assign unusedHi   = ^wrData[REG_W-1:ADDR_W];
  assign baseLine   = baseAddr[ADDR_W-1:LINE_SHIFT];
  assign limitLineX = {1'b0, limitAddr[ADDR_W-1:LINE_SHIFT]}
                    + {{IDX_W{1'b0}}, |limitAddr[LINE_SHIFT-1:0]};
  assign rangeEmpty = limitLineX <= {1'b0, baseLine};
  assign onLastLine = ({1'b0, curLine} + 1'b1) == limitLineX;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseAddr  <= '0;
      limitAddr <= '0;
      curLine   <= '0;
      curOp     <= OP_CLEAN_INV;
    end else begin
      if (strobe.loadBase)  baseAddr  <= wrData[ADDR_W-1:0];
      if (strobe.loadLimit) limitAddr <= wrData[ADDR_W-1:0];
      if (strobe.launch) begin
        curOp   <= maintOp_t'(wrData[2:1]);
        curLine <= baseLine;
      end else if (strobe.step) begin
        curLine <= curLine + 1'b1;
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      OFF_BASE:  rdData = {{PAD_W{1'b0}}, baseAddr};
      OFF_LIMIT: rdData = {{PAD_W{1'b0}}, limitAddr};
      OFF_CMD:   rdData = {{(REG_W-3){1'b0}}, curOp, busy};
      default:   rdData = '0;
    endcase
  end

  // R9
  frozen_regs_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(baseAddr) && $stable(limitAddr) && $stable(curOp));

  // R3
  step_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.step |-> ({1'b0, curLine} < limitLineX));

endmodule

// File: rtl/rme_ctrl.sv
module rme_ctrl
  import rme_pkg::*;
#(
  parameter int OFF_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [OFF_W-1:0] wrAddr,
  input  logic [1:0]       wrMode,
  input  logic             rangeEmpty,
  input  logic             onLastLine,
  input  logic             reqReady,
  output ctlStrobe_t       strobe,
  output logic             busy,
  output logic             reqValid
);

  localparam logic [OFF_W-1:0] OFF_BASE  = OFF_W'(8'h00);
  localparam logic [OFF_W-1:0] OFF_LIMIT = OFF_W'(8'h08);
  localparam logic [OFF_W-1:0] OFF_CMD   = OFF_W'(8'h10);

  typedef enum logic {ST_IDLE, ST_WALK} state_t;
  state_t state, stateNext;

  logic wrOpen;
  logic startWalk;

  assign busy     = (state == ST_WALK);
  assign reqValid = busy;
  assign wrOpen   = wrEn && !busy;

  assign strobe.loadBase  = wrOpen && (wrAddr == OFF_BASE);
  assign strobe.loadLimit = wrOpen && (wrAddr == OFF_LIMIT);
  assign strobe.launch    = wrOpen && (wrAddr == OFF_CMD);
  assign strobe.step      = reqValid && reqReady;

  assign startWalk = strobe.launch && (maintOp_t'(wrMode) != OP_RSVD) && !rangeEmpty;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (startWalk) stateNext = ST_WALK;
      ST_WALK: if (reqReady && onLastLine) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  // R7
  rsvd_no_walk_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.launch && wrMode == 2'd3) |=> !busy);

  // R5
  empty_no_walk_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.launch && rangeEmpty) |=> !busy);

  // R2
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && reqReady && onLastLine) |=> !busy);

endmodule

// File: rtl/range_maint_engine.sv
module range_maint_engine
  import rme_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int LINE_SHIFT = 6,
  parameter int REG_W      = 64,
  parameter int OFF_W      = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wrEn,
  input  logic [OFF_W-1:0]             wrAddr,
  input  logic [REG_W-1:0]             wrData,
  input  logic [OFF_W-1:0]             rdAddr,
  output logic [REG_W-1:0]             rdData,
  output logic                         reqValid,
  input  logic                         reqReady,
  output logic [1:0]                   reqOp,
  output logic [ADDR_W-LINE_SHIFT-1:0] reqLine
);

  ctlStrobe_t strobe;
  logic       busy;
  logic       rangeEmpty;
  logic       onLastLine;
  maintOp_t   curOp;

  rme_ctrl #(.OFF_W(OFF_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrMode     (wrData[2:1]),
    .rangeEmpty (rangeEmpty),
    .onLastLine (onLastLine),
    .reqReady   (reqReady),
    .strobe     (strobe),
    .busy       (busy),
    .reqValid   (reqValid)
  );

  rme_datapath #(
    .ADDR_W     (ADDR_W),
    .LINE_SHIFT (LINE_SHIFT),
    .REG_W      (REG_W),
    .OFF_W      (OFF_W)
  ) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .wrData     (wrData),
    .busy       (busy),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .rangeEmpty (rangeEmpty),
    .onLastLine (onLastLine),
    .curLine    (reqLine),
    .curOp      (curOp)
  );

  assign reqOp = curOp;

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqReady) |=> reqValid && $stable(reqLine) && $stable(reqOp));

  // R7
  no_rsvd_op_chk: assert property (@(posedge clk) disable iff (rst)
    reqValid |-> reqOp != 2'd3);

endmodule

// File: tb/range_maint_engine_bench.sv
`timescale 1ns/1ps
module range_maint_engine_bench;

  localparam int NV = 9;
  localparam logic [63:0] V_BASE [NV] = '{
    64'h1000, 64'h1010, 64'h2000, 64'h3000, 64'h3000, 64'h1000,
    64'hFF_FFFF_FFC0, 64'hFFFF_FF00_0000_1000, 64'h1020};
  localparam logic [63:0] V_LIMIT [NV] = '{
    64'h1100, 64'h1081, 64'h2040, 64'h3000, 64'h2000, 64'h1100,
    64'hFF_FFFF_FFFF, 64'hABCD_0000_0000_1080, 64'h1030};
  localparam logic [1:0]  V_MODE  [NV] = '{0, 1, 2, 0, 1, 3, 2, 0, 1};
  localparam logic [33:0] V_FIRST [NV] = '{
    34'h40, 34'h40, 34'h80, 34'h0, 34'h0, 34'h0, 34'h3_FFFF_FFFF, 34'h40, 34'h40};
  localparam int          V_COUNT [NV] = '{4, 3, 1, 0, 0, 0, 1, 2, 1};
  localparam logic        V_STALL [NV] = '{0, 1, 1, 0, 0, 0, 0, 1, 0};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [63:0] wrData = '0;
  logic [4:0]  rdAddr = '0;
  logic [63:0] rdData;
  logic        reqValid;
  logic        reqReady = 1'b0;
  logic [1:0]  reqOp;
  logic [33:0] reqLine;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  range_maint_engine u_range_maint_engine (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqLine(reqLine));

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [4:0] a, output logic [63:0] d);
    rdAddr = a;
    #0.5;
    d = rdData;
  endtask

  // Collect line requests until busy clears; called at a negedge
  task automatic collect(input logic [33:0] first, input int count, input logic [1:0] mode,
                         input logic stall, input string tag);
    logic [63:0] r;
    logic [33:0] expLine = first;
    int got = 0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      rdReg(5'h10, r);
      if (!r[0]) break;
      if (got == count) begin
        check(1'b0, {tag, " R2 busy after last line"}, r, 64'(mode) << 1);
        break;
      end
      check(reqValid && reqLine == expLine, {tag, " R3/R8 line"}, 64'(reqLine), 64'(expLine));
      check(reqOp == mode, {tag, " R6 op"}, 64'(reqOp), 64'(mode));
      reqReady = stall ? cyc[0] : 1'b1;
      @(negedge clk);
      if (reqReady) begin got++; expLine++; end
      reqReady = 1'b0;
    end
    check(got == count, {tag, " R4/R5 line count"}, 64'(got), 64'(count));
    rdReg(5'h10, r);
    check(r == (64'(mode) << 1), {tag, " R6 command readback"}, r, 64'(mode) << 1);
    check(!reqValid, {tag, " R2 valid low when done"}, 64'(reqValid), 64'h0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    rdReg(5'h00, r); check(r == 0, "R10 base after reset", r, 0);
    rdReg(5'h08, r); check(r == 0, "R10 limit after reset", r, 0);
    rdReg(5'h10, r); check(r == 0, "R10 command after reset", r, 0);
    check(!reqValid, "R10 valid after reset", 64'(reqValid), 0);

    // R1 masking and offsets
    wrReg(5'h00, 64'hFFFF_FFFF_FFFF_FFFF);
    rdReg(5'h00, r); check(r == 64'hFF_FFFF_FFFF, "R1 base mask", r, 64'hFF_FFFF_FFFF);
    wrReg(5'h08, 64'h1234_5678_9ABC_DEF0);
    rdReg(5'h08, r); check(r == 64'h78_9ABC_DEF0, "R1 limit mask", r, 64'h78_9ABC_DEF0);
    rdReg(5'h18, r); check(r == 0, "R1 unmapped offset", r, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("vec%0d", i);
      wrReg(5'h00, V_BASE[i]);
      wrReg(5'h08, V_LIMIT[i]);
      wrReg(5'h10, 64'(V_MODE[i]) << 1);
      rdReg(5'h10, r);
      check(r[0] == (V_COUNT[i] > 0), {tag, " R2/R5/R7 busy after launch"}, 64'(r[0]),
            64'(V_COUNT[i] > 0));
      collect(V_FIRST[i], V_COUNT[i], V_MODE[i], V_STALL[i], tag);
    end

    // R9 writes ignored while busy
    wrReg(5'h00, 64'h0);
    wrReg(5'h08, 64'h400);
    wrReg(5'h10, 64'h0);
    wrReg(5'h00, 64'h5000);
    wrReg(5'h10, 64'h4);
    wrReg(5'h08, 64'h9000);
    rdReg(5'h00, r); check(r == 0, "R9 base frozen", r, 0);
    rdReg(5'h08, r); check(r == 64'h400, "R9 limit frozen", r, 64'h400);
    rdReg(5'h10, r); check(r == 64'h1, "R9 command frozen", r, 64'h1);
    check(reqValid && reqLine == 0, "R9/R8 held first line", 64'(reqLine), 0);
    collect(34'h0, 16, 2'd0, 1'b0, "busyIgnore R9");

    // R10 reset in the middle of a walk
    wrReg(5'h10, 64'h2);
    check(reqValid, "R10 walk started", 64'(reqValid), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!reqValid, "R10 valid cleared mid-walk", 64'(reqValid), 0);
    rdReg(5'h10, r); check(r == 0, "R10 command cleared mid-walk", r, 0);
    rdReg(5'h08, r); check(r == 0, "R10 limit cleared mid-walk", r, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule